// File: doc/BRIEF.md
# BIST Result Status Reporter

This block sits between a memory self-test engine and the tester pins and reduces the engine's event strobes to a 3-bit result bus. The engine supplies three single-cycle inputs: a failing compare, an address-sweep expiry and an end-of-test mark. The tester reads a fail flag, a progress pulse and a completion flag. The fail flag has two reporting modes, selected by one bit of a small control register. In pulse mode the flag follows each failing compare for one cycle, so failures can be counted. In sticky mode the flag is latched from the first failure onward.

The control register is loaded one bit per clock from a serial data pin while a shift-enable pin is high. Shifting takes effect only while the run input is low, which freezes the mode for the length of a test. A sequencer with three states decides when engine events count. The states are IDLE, ACTIVE and FINISHED, and they have these transitions:
- IDLE→ACTIVE ("launch"): run is sampled high in IDLE. This clears the held flags.
- ACTIVE→FINISHED ("complete"): run is high and the end-of-test mark arrives.
- ACTIVE→IDLE ("abort"): run drops during a test.
- FINISHED→IDLE ("release"): run drops after the test has completed.

Engine events are counted only in ACTIVE while run is high. The active-low self-test reset clears everything and must be held low in functional mode.

Top module: `bist_status_reporter`

## Requirements
- R1: While `rst_bist_n` is low, `result_o` is 3'b000 and the control register is all zero, so the fail flag starts in sticky mode. The sequencer returns to IDLE.
- R2: Each clock with `cfg_shift_i` high and `run_i` low shifts `cfg_data_i` into the 8-bit control register at the top, moving the register toward bit 0. After eight shifts, the first bit shifted lands in bit 0. Only the last eight bits shifted count. Bit 5 selects pulse mode when 1 and sticky mode when 0.
- R3: While `run_i` is high, `cfg_shift_i` has no effect on the control register or on the reporting mode.
- R4: In pulse mode, `result_o[1]` is high in the cycle after each counted failing compare and low in the cycle after a counted cycle with no failure.
- R5: In sticky mode, `result_o[1]` goes high in the cycle after the first counted failure. It stays high until reset or the next launch.
- R6: `result_o[0]` is high for exactly the one cycle after each counted address-expire event.
- R7: A counted end-of-test mark sets `result_o[2]` in the next cycle and moves the sequencer to FINISHED. There, further fail, expire and end-of-test inputs are ignored. `result_o[2]` holds until reset or the next launch.
- R8: Engine events are not counted in IDLE, in FINISHED, or in any cycle with `run_i` low.
- R9: A launch takes one cycle, in which no event is counted. In the cycle after the launch, `result_o[2]` and `result_o[1]` read 0.
- R10: Dropping `run_i` during a test aborts to IDLE, and the fail and done flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_bist_n | input | 1 | Self-test reset, active low, asynchronous |
| run_i | input | 1 | Test run enable |
| cfg_shift_i | input | 1 | Control register shift enable |
| cfg_data_i | input | 1 | Control register serial data |
| cmp_fail_i | input | 1 | Failing compare strobe from the engine |
| addr_expire_i | input | 1 | Address sweep expiry strobe |
| test_done_i | input | 1 | End-of-test strobe |
| result_o | output | 3 | [0] expire pulse, [1] fail flag, [2] done flag |

## Verification
The reporting mode is never visible directly, so a wrong mode bit, a wrong shift direction or a shift that leaks during a run all show up as a wrong fail flag. That wrong flag appears one cycle after the next counted failure, either as a pulse that fails to drop or as a level that drops. A sequencer stuck in the wrong state shows up as an expire pulse or a done flag one cycle after an event that should have been ignored. It can also show up as a flag that survives a launch. A missing flag clear becomes visible in the cycle right after a launch. The bench interleaves directed sequences for each of these with a long seeded random run that includes resets in the middle of tests.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACTIVE   = 2'd1,
        ST_FINISHED = 2'd2
    } bsr_state_e;

    localparam int RES_W      = 3;
    localparam int RES_EXPIRE = 0;
    localparam int RES_FAIL   = 1;
    localparam int RES_DONE   = 2;

endpackage

// File: rtl/bsr_cfg_shift.sv
module bsr_cfg_shift #(
    parameter int CFG_W     = 8,
    parameter int MODE_BIT  = 5,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    input  logic             freeze,
    output logic [CFG_W-1:0] cfg_q,
    output logic             pulse_mode
);

    logic [CFG_W-1:0] cfg_next;

    generate
        if (LSB_FIRST) begin : g_lsb_first
            always_comb cfg_next = {din, cfg_q[CFG_W-1:1]};
        end else begin : g_msb_first
            always_comb cfg_next = {cfg_q[CFG_W-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (shift_en && !freeze) begin
            cfg_q <= cfg_next;
        end
    end

    assign pulse_mode = cfg_q[MODE_BIT];

endmodule

// File: rtl/bsr_seq_fsm.sv
module bsr_seq_fsm
    import bsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       done_ev,
    output bsr_state_e state_o,
    output logic       start_o,
    output logic       live_o
);

    bsr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!run)         state_d = ST_IDLE;
                else if (done_ev) state_d = ST_FINISHED;
            end
            ST_FINISHED: begin
                if (!run) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_o = 1'b0;
        live_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:     start_o = run;
            ST_ACTIVE:   live_o  = run;
            ST_FINISHED: ;
            default:     ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/bsr_result_regs.sv
module bsr_result_regs
    import bsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             live,
    input  logic             pulse_mode,
    input  logic             fail_ev,
    input  logic             expire_ev,
    input  logic             done_ev,
    output logic [RES_W-1:0] result_o
);

    logic expire_q, fail_q, done_q;
    logic fail_hit;

    assign fail_hit = live && fail_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expire_q <= 1'b0;
        end else begin
            expire_q <= live && expire_ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (pulse_mode) begin
            fail_q <= fail_hit;
        end else if (start) begin
            fail_q <= 1'b0;
        end else if (fail_hit) begin
            fail_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (start) begin
            done_q <= 1'b0;
        end else if (live && done_ev) begin
            done_q <= 1'b1;
        end
    end

    always_comb begin
        result_o             = '0;
        result_o[RES_EXPIRE] = expire_q;
        result_o[RES_FAIL]   = fail_q;
        result_o[RES_DONE]   = done_q;
    end

endmodule

// File: rtl/bist_status_reporter.sv
module bist_status_reporter
    import bsr_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int MODE_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_bist_n,
    input  logic             run_i,
    input  logic             cfg_shift_i,
    input  logic             cfg_data_i,
    input  logic             cmp_fail_i,
    input  logic             addr_expire_i,
    input  logic             test_done_i,
    output logic [RES_W-1:0] result_o
);

    localparam int MODE_IDX = (MODE_BIT < CFG_W) ? MODE_BIT : CFG_W - 1;

    logic [CFG_W-1:0] cfg_q;
    logic             pulse_mode;
    logic             start_run;
    logic             live;
    bsr_state_e       seq_state;

    bsr_cfg_shift #(
        .CFG_W     (CFG_W),
        .MODE_BIT  (MODE_IDX),
        .LSB_FIRST (1'b1)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_bist_n),
        .shift_en   (cfg_shift_i),
        .din        (cfg_data_i),
        .freeze     (run_i),
        .cfg_q      (cfg_q),
        .pulse_mode (pulse_mode)
    );

    bsr_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_bist_n),
        .run     (run_i),
        .done_ev (test_done_i),
        .state_o (seq_state),
        .start_o (start_run),
        .live_o  (live)
    );

    bsr_result_regs u_res (
        .clk        (clk),
        .rst_n      (rst_bist_n),
        .start      (start_run),
        .live       (live),
        .pulse_mode (pulse_mode),
        .fail_ev    (cmp_fail_i),
        .expire_ev  (addr_expire_i),
        .done_ev    (test_done_i),
        .result_o   (result_o)
    );

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker
    import bsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             fail_ev,
    input logic             expire_ev,
    input logic             pulse_mode,
    input logic             start,
    input logic             live,
    input bsr_state_e       state,
    input logic [RES_W-1:0] result
);

    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(pulse_mode));

    p_fail_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && $past(pulse_mode) && result[RES_FAIL]) |-> $past(fail_ev && live));

    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && result[RES_FAIL] && !start) |=> result[RES_FAIL]);

    p_expire_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result[RES_EXPIRE] |-> $past(expire_ev && live));

    p_expire_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && expire_ev) |=> result[RES_EXPIRE]);

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result[RES_DONE] && !start) |=> result[RES_DONE]);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> !result[RES_EXPIRE]);

    p_launch_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (result[RES_DONE] == 1'b0) && (result[RES_FAIL] == 1'b0));

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !run) |=> (state == ST_IDLE));

endmodule

bind bist_status_reporter bsr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_bist_n),
    .run        (run_i),
    .fail_ev    (cmp_fail_i),
    .expire_ev  (addr_expire_i),
    .pulse_mode (pulse_mode),
    .start      (start_run),
    .live       (live),
    .state      (seq_state),
    .result     (result_o)
);

// File: tb/sim_bist_status_reporter.sv
`timescale 1ns/1ps
module sim_bist_status_reporter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, sh = 1'b0, din = 1'b0;
    logic       fail = 1'b0, expv = 1'b0, done = 1'b0;
    logic [2:0] res;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_ctrl = 8'h00;
    int         m_st   = 0;      // 0 idle, 1 active, 2 finished
    logic [2:0] m_res  = 3'b000;

    always #2.5 clk = ~clk;

    bist_status_reporter u0 (
        .clk           (clk),
        .rst_bist_n    (rst_n),
        .run_i         (run),
        .cfg_shift_i   (sh),
        .cfg_data_i    (din),
        .cmp_fail_i    (fail),
        .addr_expire_i (expv),
        .test_done_i   (done),
        .result_o      (res)
    );

    function automatic logic [7:0] f_ctrl(logic [7:0] c, logic s, logic d, logic r);
        return (s && !r) ? {d, c[7:1]} : c;
    endfunction

    function automatic int f_state(int st, logic r, logic d);
        if (st == 0) return r ? 1 : 0;
        if (st == 1) return !r ? 0 : (d ? 2 : 1);
        return r ? 2 : 0;
    endfunction

    function automatic logic [2:0] f_res(logic [2:0] q, int st, logic pm,
                                          logic r, logic f, logic e, logic d);
        logic live, start;
        logic [2:0] n;
        live  = (st == 1) && r;
        start = (st == 0) && r;
        n[0]  = live && e;
        if (pm)              n[1] = live && f;
        else if (start)      n[1] = 1'b0;
        else if (live && f)  n[1] = 1'b1;
        else                 n[1] = q[1];
        if (start)           n[2] = 1'b0;
        else if (live && d)  n[2] = 1'b1;
        else                 n[2] = q[2];
        return n;
    endfunction

    task automatic compare(input string tag);
        string t;
        n_cmp++;
        if (res !== m_res) begin
            n_bad++;
            t = tag;
            if (tag == "RND") begin
                if (res[1] !== m_res[1])      t = m_ctrl[5] ? "R4" : "R5";
                else if (res[0] !== m_res[0]) t = "R6";
                else                          t = "R7";
            end
            $display("FAIL %s: result_o=%b expected=%b", t, res, m_res);
        end
    endtask

    task automatic step(input logic s, input logic d, input logic r,
                        input logic f, input logic e, input logic dn,
                        input string tag);
        @(negedge clk);
        sh = s; din = d; run = r; fail = f; expv = e; done = dn;
        @(posedge clk);
        m_res  = f_res(m_res, m_st, m_ctrl[5], r, f, e, dn);
        m_st   = f_state(m_st, r, dn);
        m_ctrl = f_ctrl(m_ctrl, s, d, r);
        #1;
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        sh = 0; din = 0; run = 0; fail = 0; expv = 0; done = 0;
        m_ctrl = 8'h00; m_st = 0; m_res = 3'b000;
        @(posedge clk);
        #1;
        compare(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_cfg(input logic [7:0] v, input logic r, input string tag);
        for (int i = 0; i < 8; i++) step(1'b1, v[i], r, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: result_o=%b expected=run completion", res);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: pulse mode via bit 5, LSB first
        load_cfg(8'b0010_0000, 1'b0, "R2");
        step(0, 0, 1, 0, 0, 0, "R9");          // launch
        step(0, 0, 1, 1, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, "R4");
        step(0, 0, 1, 1, 0, 0, "R4");
        step(0, 0, 1, 1, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, "R4");
        // R3: shifting during run must not leave pulse mode
        load_cfg(8'h00, 1'b1, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        step(0, 0, 1, 0, 0, 0, "R3");
        // R6: expire pulses
        step(0, 0, 1, 0, 1, 0, "R6");
        step(0, 0, 1, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 1, 0, "R6");
        // R7: done, then events ignored in FINISHED
        step(0, 0, 1, 0, 0, 1, "R7");
        step(0, 0, 1, 1, 1, 0, "R7");
        step(0, 0, 1, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, "R7");
        // R8: idle ignores events
        step(0, 0, 0, 1, 1, 1, "R8");
        step(0, 0, 0, 1, 1, 0, "R8");

        // R2: sticky mode, R9 clear on launch, R5 hold
        load_cfg(8'b1101_1111, 1'b0, "R2");
        step(0, 0, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 1, 0, 0, "R5");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, i[0], 0, "R5");
        // R10: abort keeps flags
        step(0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, "R10");

        // R2: over-shift, last eight bits count (bit 5 set)
        step(1, 0, 0, 0, 0, 0, "R2");
        load_cfg(8'b0010_0000, 1'b0, "R2");
        step(0, 0, 1, 0, 0, 0, "R2");
        step(0, 0, 1, 1, 0, 0, "R2");
        step(0, 0, 1, 0, 0, 0, "R2");

        // R1: reset in the middle of a test returns to sticky mode
        step(0, 0, 1, 1, 1, 0, "R1");
        do_reset("R1");
        step(0, 0, 1, 0, 0, 0, "R1");
        step(0, 0, 1, 1, 0, 0, "R1");
        step(0, 0, 1, 0, 0, 0, "R1");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic r;
            r = run;
            if ($urandom_range(0, 15) == 0) r = ~r;
            if ($urandom_range(0, 499) == 0) begin
                do_reset("R1");
            end else begin
                step(($urandom_range(0, 3) == 0), $urandom_range(0, 1), r,
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                     ($urandom_range(0, 31) == 0), "RND");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule